// File: doc/BRIEF.md
# Stale-Line Read Permission Controller

This controller sits beside one cache line and decides, access by access, whether a processor may keep reading that line after another processor has invalidated it. An invalidate does not throw the line away. The controller marks it stale, records the vector timestamp that came with the invalidate, and answers at once with an acknowledgment. That acknowledgment carries an expiration vector: the local processor clock with its own entry advanced by a fixed number of barriers.

A load to a stale line is checked against the recorded stamp. If the processor clock is no newer than the stamp in any entry, the old data is still consistent and is served. If any entry is newer, the load is reported as a miss. The first stale data that is served starts a hardware prefetch of the fresh copy, and further stale reads continue while that prefetch is outstanding. When the fill returns, it replaces the stale copy and the stale mark is cleared. A store never completes on a stale line.

The block decides permission only. Data storage, replacement and the rest of the coherence protocol stay outside it.

Top module: `stale_read_ctrl`

## Requirements
- R1: After reset the line is not stale and no prefetch has been issued. With no access and no invalidate, `hit_o`, `stale_hit_o`, `miss_o`, `prefetch_o` and `ack_valid_o` are all 0, and `stale_o` is 0.
- R2: An invalidate taken while `resident_i` is 1 sets `stale_o` from the next cycle and records `inv_stamp_i`. The recorded stamp stays unchanged until the next invalidate. An invalidate taken while `resident_i` is 0 does not set the stale mark.
- R3: In the same cycle as every invalidate, `ack_valid_o` is 1. `ack_expire_o` equals `proc_vc_i`, except that entry `MY_ID` is increased by `EXP_INC` modulo 2^`TSW`. Vectors are packed with entry i at bits [i*TSW +: TSW].
- R4: A load to a resident stale line is safe only when every entry of `proc_vc_i` is less than or equal to the same entry of the recorded stamp. A safe load gives `stale_hit_o`, and an unsafe load gives `miss_o`. For example, a clock of [2,2] against a stamp of [0,1] is unsafe.
- R5: A store to a stale line always gives `miss_o` and never `hit_o` or `stale_hit_o`.
- R6: The first safe stale load of an episode raises `prefetch_o` in that same cycle. Later safe stale loads in the same episode do not raise it again.
- R7: An unsafe stale load gives a miss and issues no prefetch, and the line stays stale.
- R8: `fill_valid_i` clears the stale mark and the prefetch-issued bit from the next cycle. A later load to the resident line is then a plain hit.
- R9: When an invalidate and a fill arrive in the same cycle, the invalidate wins. The line is stale with the new stamp, and a new prefetch is allowed. Every invalidate to a resident line starts a new episode.
- R10: A load or store to a resident line that is not stale is a hit. Any access while `resident_i` is 0 is a miss.
- R11: Each access raises exactly one of `hit_o`, `stale_hit_o` and `miss_o` in its own cycle. None of the three is raised without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resident_i | input | 1 | Line holds a copy |
| proc_vc_i | input | NPROC*TSW | Local processor vector clock |
| inv_valid_i | input | 1 | Invalidate arriving this cycle |
| inv_stamp_i | input | NPROC*TSW | Vector timestamp of the invalidate |
| ack_valid_o | output | 1 | Invalidate acknowledgment |
| ack_expire_o | output | NPROC*TSW | Expiration vector carried by the acknowledgment |
| acc_valid_i | input | 1 | Processor access this cycle |
| acc_store_i | input | 1 | Access is a store (0 = load) |
| hit_o | output | 1 | Served from a current copy |
| stale_hit_o | output | 1 | Load served from the stale copy |
| miss_o | output | 1 | Access must go out as a miss |
| prefetch_o | output | 1 | Start a prefetch of the fresh data |
| fill_valid_i | input | 1 | Fresh data returned this cycle |
| stale_o | output | 1 | Line is currently stale |

## Verification
The risky overlap is an invalidate that lands in the same cycle as a returning fill. The fill would clear the mark, and the invalidate must set it again with the new stamp and reopen the prefetch allowance. A directed case sets up a stale episode with its prefetch already issued, then drives both inputs on one edge. It then checks that `stale_o` is still high and that the next safe load prefetches again. Random cycles also put an invalidate together with a stale load or a fill about once in several dozen cycles, and each such cycle is judged against a bench model that applies the invalidate after the fill.

// File: rtl/stale_pkg.sv
package stale_pkg;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_HIT   = 2'd1,
    RESP_STALE = 2'd2,
    RESP_MISS  = 2'd3
  } resp_e;

  // Grant decision for one access, from line state and the safety verdict.
  function automatic resp_e decide(input logic valid, input logic store,
                                   input logic resident, input logic stale,
                                   input logic safe);
    if (!valid)         return RESP_NONE;
    else if (!resident) return RESP_MISS;
    else if (!stale)    return RESP_HIT;
    else if (store)     return RESP_MISS;
    else if (safe)      return RESP_STALE;
    else                return RESP_MISS;
  endfunction

endpackage

// File: rtl/sr_safety_cmp.sv
module sr_safety_cmp #(
  parameter int NPROC = 4,
  parameter int TSW   = 8
) (
  input  logic [NPROC*TSW-1:0] proc_vc_i,
  input  logic [NPROC*TSW-1:0] stamp_i,
  output logic                 safe_o
);
  logic [NPROC-1:0] entry_ok;

  for (genvar g = 0; g < NPROC; g++) begin : g_entry
    assign entry_ok[g] = proc_vc_i[g*TSW +: TSW] <= stamp_i[g*TSW +: TSW];
  end

  assign safe_o = &entry_ok;
endmodule

// File: rtl/sr_expire_gen.sv
module sr_expire_gen #(
  parameter int NPROC   = 4,
  parameter int TSW     = 8,
  parameter int MY_ID   = 0,
  parameter int EXP_INC = 4
) (
  input  logic [NPROC*TSW-1:0] proc_vc_i,
  output logic [NPROC*TSW-1:0] expire_o
);
  localparam logic [TSW-1:0] INC = TSW'(EXP_INC);

  for (genvar g = 0; g < NPROC; g++) begin : g_entry
    if (g == MY_ID) begin : g_own
      assign expire_o[g*TSW +: TSW] = proc_vc_i[g*TSW +: TSW] + INC;
    end else begin : g_copy
      assign expire_o[g*TSW +: TSW] = proc_vc_i[g*TSW +: TSW];
    end
  end
endmodule

// File: rtl/sr_state.sv
module sr_state #(
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_stale_i,
  input  logic [VW-1:0] new_stamp_i,
  input  logic          clear_i,
  input  logic          mark_pf_i,
  output logic          stale_o,
  output logic          pf_issued_o,
  output logic [VW-1:0] stamp_o
);
  logic          stale_q, pf_q;
  logic [VW-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stale_q <= 1'b0;
      pf_q    <= 1'b0;
      stamp_q <= '0;
    end else if (set_stale_i) begin
      stale_q <= 1'b1;
      pf_q    <= 1'b0;
      stamp_q <= new_stamp_i;
    end else if (clear_i) begin
      stale_q <= 1'b0;
      pf_q    <= 1'b0;
    end else if (mark_pf_i) begin
      pf_q    <= 1'b1;
    end
  end

  assign stale_o     = stale_q;
  assign pf_issued_o = pf_q;
  assign stamp_o     = stamp_q;

  AST_STAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !set_stale_i |=> $stable(stamp_q)); // R2
  AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && !set_stale_i |=> !stale_q && !pf_q); // R8
  AST_INV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_stale_i |=> stale_q && !pf_q); // R9
endmodule

// File: rtl/stale_read_ctrl.sv
module stale_read_ctrl #(
  parameter int NPROC   = 4,
  parameter int TSW     = 8,
  parameter int MY_ID   = 0,
  parameter int EXP_INC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 resident_i,
  input  logic [NPROC*TSW-1:0] proc_vc_i,
  input  logic                 inv_valid_i,
  input  logic [NPROC*TSW-1:0] inv_stamp_i,
  output logic                 ack_valid_o,
  output logic [NPROC*TSW-1:0] ack_expire_o,
  input  logic                 acc_valid_i,
  input  logic                 acc_store_i,
  output logic                 hit_o,
  output logic                 stale_hit_o,
  output logic                 miss_o,
  output logic                 prefetch_o,
  input  logic                 fill_valid_i,
  output logic                 stale_o
);
  import stale_pkg::*;

  localparam int VW = NPROC * TSW;

  if (EXP_INC < 1 || MY_ID < 0 || MY_ID >= NPROC) begin : g_bad_param
    $error("stale_read_ctrl: EXP_INC must be >= 1 and MY_ID inside the vector");
  end

  logic          stale_w, pf_issued_w, safe_w, set_stale_w, mark_pf_w;
  logic [VW-1:0] stamp_w;
  resp_e         resp_w;

  assign set_stale_w = inv_valid_i && resident_i;

  sr_state #(.VW(VW)) i_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_stale_i(set_stale_w),
    .new_stamp_i(inv_stamp_i),
    .clear_i    (fill_valid_i),
    .mark_pf_i  (mark_pf_w),
    .stale_o    (stale_w),
    .pf_issued_o(pf_issued_w),
    .stamp_o    (stamp_w)
  );

  sr_safety_cmp #(.NPROC(NPROC), .TSW(TSW)) i_cmp (
    .proc_vc_i(proc_vc_i),
    .stamp_i  (stamp_w),
    .safe_o   (safe_w)
  );

  sr_expire_gen #(.NPROC(NPROC), .TSW(TSW), .MY_ID(MY_ID), .EXP_INC(EXP_INC)) i_exp (
    .proc_vc_i(proc_vc_i),
    .expire_o (ack_expire_o)
  );

  assign resp_w      = decide(acc_valid_i, acc_store_i, resident_i, stale_w, safe_w);
  assign hit_o       = resp_w == RESP_HIT;
  assign stale_hit_o = resp_w == RESP_STALE;
  assign miss_o      = resp_w == RESP_MISS;
  assign mark_pf_w   = stale_hit_o && !pf_issued_w;
  assign prefetch_o  = mark_pf_w;
  assign ack_valid_o = inv_valid_i;
  assign stale_o     = stale_w;

  AST_STORE_NEVER_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && acc_store_i && stale_w |-> miss_o && !hit_o && !stale_hit_o); // R5
  AST_STALE_ONLY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    stale_hit_o |-> safe_w && stale_w && !acc_store_i); // R4
  AST_UNSAFE_KEEPS_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && !acc_store_i && stale_w && !safe_w && !fill_valid_i |=> stale_w); // R7
  AST_SINGLE_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_o && !inv_valid_i && !fill_valid_i |=> !prefetch_o); // R6
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_o, stale_hit_o, miss_o}) == (acc_valid_i ? 1 : 0)); // R11
  AST_ACK_EVERY_INV: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid_i |-> ack_valid_o); // R3
endmodule

// File: tb/test_stale_read_ctrl.sv
module test_stale_read_ctrl;
  localparam int NP  = 4;
  localparam int TW  = 8;
  localparam int ME  = 0;
  localparam int INC = 4;
  localparam int VW  = NP * TW;

  logic clk = 1'b0;
  logic rst_n;
  logic resident_i, inv_valid_i, acc_valid_i, acc_store_i, fill_valid_i;
  logic [VW-1:0] proc_vc_i, inv_stamp_i;
  logic ack_valid_o, hit_o, stale_hit_o, miss_o, prefetch_o, stale_o;
  logic [VW-1:0] ack_expire_o;

  int n_vec = 0;
  int n_bad = 0;

  // model state
  bit m_stale, m_pf;
  logic [VW-1:0] m_stamp;

  always #10 clk = ~clk;

  stale_read_ctrl #(.NPROC(NP), .TSW(TW), .MY_ID(ME), .EXP_INC(INC)) i_stale_read_ctrl (
    .clk(clk), .rst_n(rst_n), .resident_i(resident_i), .proc_vc_i(proc_vc_i),
    .inv_valid_i(inv_valid_i), .inv_stamp_i(inv_stamp_i), .ack_valid_o(ack_valid_o),
    .ack_expire_o(ack_expire_o), .acc_valid_i(acc_valid_i), .acc_store_i(acc_store_i),
    .hit_o(hit_o), .stale_hit_o(stale_hit_o), .miss_o(miss_o), .prefetch_o(prefetch_o),
    .fill_valid_i(fill_valid_i), .stale_o(stale_o));

  function automatic logic [VW-1:0] vc(int a, int b, int c, int d);
    return {d[TW-1:0], c[TW-1:0], b[TW-1:0], a[TW-1:0]};
  endfunction

  function automatic bit older_or_equal(logic [VW-1:0] p, logic [VW-1:0] s);
    for (int i = 0; i < NP; i++)
      if (int'(p[i*TW +: TW]) > int'(s[i*TW +: TW])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [VW-1:0] expected_expire(logic [VW-1:0] p);
    logic [VW-1:0] r = p;
    r[ME*TW +: TW] = TW'((int'(p[ME*TW +: TW]) + INC) % (1 << TW));
    return r;
  endfunction

  task automatic check(string tag, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, compare outputs, then advance the model at the edge.
  task automatic step(bit res, bit inv, logic [VW-1:0] stamp, logic [VW-1:0] pvc,
                      bit acc, bit st, bit fill, string tag);
    bit e_hit, e_sh, e_miss, e_pf, safe;
    string t_resp;
    @(negedge clk);
    resident_i = res; inv_valid_i = inv; inv_stamp_i = stamp; proc_vc_i = pvc;
    acc_valid_i = acc; acc_store_i = st; fill_valid_i = fill;
    #1;
    safe = older_or_equal(pvc, m_stamp);
    e_hit = 0; e_sh = 0; e_miss = 0;
    if (acc) begin
      if (!res) e_miss = 1;
      else if (!m_stale) e_hit = 1;
      else if (st) e_miss = 1;
      else if (safe) e_sh = 1;
      else e_miss = 1;
    end
    e_pf = e_sh && !m_pf;
    if (tag != "") t_resp = tag;
    else if (!acc) t_resp = "R11";
    else if (res && m_stale && st) t_resp = "R5";
    else if (res && m_stale) t_resp = "R4";
    else t_resp = "R10";
    check(t_resp, "hit", VW'(hit_o), VW'(e_hit));
    check(t_resp, "stale_hit", VW'(stale_hit_o), VW'(e_sh));
    check(t_resp, "miss", VW'(miss_o), VW'(e_miss));
    check(tag != "" ? tag : "R6", "prefetch", VW'(prefetch_o), VW'(e_pf));
    check(tag != "" ? tag : "R2", "stale", VW'(stale_o), VW'(m_stale));
    check("R3", "ack_valid", VW'(ack_valid_o), VW'(inv));
    if (inv) check("R3", "ack_expire", ack_expire_o, expected_expire(pvc));
    @(posedge clk);
    if (inv && res) begin m_stale = 1; m_pf = 0; m_stamp = stamp; end
    else if (fill) begin m_stale = 0; m_pf = 0; end
    else if (e_pf) m_pf = 1;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; resident_i = 1; inv_valid_i = 0; acc_valid_i = 0; acc_store_i = 0;
    fill_valid_i = 0; proc_vc_i = '0; inv_stamp_i = '0;
    m_stale = 0; m_pf = 0; m_stamp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    step(1, 0, '0, '0, 0, 0, 0, "R1");
    // R10 plain hits and non-resident miss
    step(1, 0, '0, vc(1,1,1,1), 1, 0, 0, "R10");
    step(1, 0, '0, vc(1,1,1,1), 1, 1, 0, "R10");
    step(0, 0, '0, vc(1,1,1,1), 1, 0, 0, "R10");
    // R2 non-resident invalidate leaves line fresh
    step(0, 1, vc(5,5,5,5), vc(0,0,0,0), 0, 0, 0, "R2");
    step(1, 0, '0, vc(0,0,0,0), 1, 0, 0, "R2");
    // R2 resident invalidate with stamp [0,1], clock [2,2]
    step(1, 1, vc(0,1,0,0), vc(2,2,0,0), 0, 0, 0, "R2");
    // R7 unsafe load: miss, no prefetch, stays stale
    step(1, 0, '0, vc(2,2,0,0), 1, 0, 0, "R7");
    step(1, 0, '0, vc(2,2,0,0), 0, 0, 0, "R7");
    // R6 first safe stale read prefetches once
    step(1, 0, '0, vc(0,1,0,0), 1, 0, 0, "R6");
    step(1, 0, '0, vc(0,0,0,0), 1, 0, 0, "R6");
    // R5 store to stale line
    step(1, 0, '0, vc(0,0,0,0), 1, 1, 0, "R5");
    // R8 fill clears
    step(1, 0, '0, vc(0,0,0,0), 0, 0, 1, "R8");
    step(1, 0, '0, vc(3,3,3,3), 1, 0, 0, "R8");
    // R9 invalidate and fill together
    step(1, 1, vc(7,7,7,7), vc(1,1,1,1), 0, 0, 0, "R9");
    step(1, 0, '0, vc(1,1,1,1), 1, 0, 0, "R9");
    step(1, 1, vc(6,6,6,6), vc(1,1,1,1), 0, 0, 1, "R9");
    step(1, 0, '0, vc(1,1,1,1), 1, 0, 0, "R9");
    // R3 expiration wraps in own entry
    step(1, 1, vc(9,9,9,9), vc(254,3,4,5), 0, 0, 0, "R3");
    step(1, 0, '0, vc(0,0,0,0), 0, 0, 1, "R11");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [VW-1:0] s, p;
      for (int i = 0; i < NP; i++) begin
        s[i*TW +: TW] = TW'($urandom % 4);
        p[i*TW +: TW] = TW'($urandom % 4);
      end
      step(($urandom % 10) != 0, ($urandom % 8) == 0, s, p,
           ($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 10) == 0, "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule